// File: doc/BRIEF.md
# One-wire bus master bit engine

This block is the bit-level engine of a master for a single-wire open-drain bus with a pullup. It runs from a fixed clock and takes one command at a time. A command is a bus reset, a one-bit write or a one-bit read. Each command carries its own speed flag, so it runs with the standard or the overdrive timing profile. A reset command also carries a flag that selects the extended reset-high window, which networks with mixed device types need.

The block drives a single pulldown request (`bus_pull`, high means pull the line low). It samples `bus_in`, a line level that has already been synchronized to `clk`. After a reset it reports whether any slave answered with a presence pulse. After a read it reports the sampled bit. `busy` covers the whole operation. `done` pulses for one cycle once the full slot or reset window has passed. All low times, sample points and window lengths are parameters in clock cycles. `rst_n` is asynchronous active-low and must be released synchronously to `clk` by the surrounding logic.

Top module: `owm_bit_engine`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `bus_pull`, `done`, `presence` and `rd_bit` are all 0. Asserting `rst_n` low in the middle of an operation aborts it and releases the line.
- R2: A command is accepted on a rising edge where `cmd_valid` is 1, `busy` is 0 and `cmd_op` is not 2'b11. Encodings: 2'b00 = reset, 2'b01 = write, 2'b10 = read. After that edge `busy` is 1 for exactly T cycles, where T is the total length of the operation. `cmd_valid` while `busy` is 1, and op 2'b11 at any time, have no effect.
- R3: A reset drives `bus_pull` high for RSTL cycles, starting in the cycle after the accepting edge. RSTL is `STD_RSTL` at standard speed and `OD_RSTL` at overdrive speed.
- R4: A reset samples `bus_in` once, at the end of cycle RSTL+MSP counted from the accepting edge (cycle 0). `presence` becomes 1 if the line was low there and 0 if it was high.
- R5: The total length of a reset is RSTL+RSTH. RSTH is the minimum reset-high window when `cmd_ext_rst` is 0 and the extended window when it is 1, for the selected speed.
- R6: A write drives `bus_pull` high for W1L cycles when `cmd_bit` is 1 and for W0L cycles when `cmd_bit` is 0, starting in the cycle after the accepting edge.
- R7: A read drives `bus_pull` high for RL cycles. It then samples `bus_in` once, at the end of cycle MSR counted from the accepting edge. `rd_bit` takes the sampled line level. A write leaves `rd_bit` and `presence` unchanged.
- R8: Writes and reads last SLOT cycles in total. `done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 again (cycle T).
- R9: `cmd_fast` = 1 selects the overdrive values (`OD_*`) for every low time, sample point and window length of that command. `cmd_fast` = 0 selects the standard values (`STD_*`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 reset, 01 write, 10 read, 11 no operation |
| cmd_bit | input | 1 | Bit value to write |
| cmd_fast | input | 1 | 1 = overdrive timing profile |
| cmd_ext_rst | input | 1 | 1 = extended reset-high window |
| bus_in | input | 1 | Synchronized line level |
| bus_pull | output | 1 | 1 = pull the line low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| presence | output | 1 | Presence pulse seen at the last reset |
| rd_bit | output | 1 | Bit sampled by the last read |

## Verification
All timing is counted from the accepting edge, which starts cycle 0. `bus_pull` and `busy` rise in cycle 0, `bus_pull` falls in cycle L, `done` appears in cycle T, and the sampled value is registered at the end of cycle S. The bench samples every output at the falling clock edge in the middle of each cycle k. Its slave model decides the line level for cycle k at the same falling edge, so the sampling edge at the end of cycle S sees exactly the level the bench chose for cycle S. Each vector places its slave pulldown window just inside or just outside that cycle, so a sample point off by one cycle changes the reported bit.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } op_e;
endpackage

// File: rtl/owm_timing_sel.sv
module owm_timing_sel
  import owm_pkg::*;
#(
  parameter int CW           = 17,
  parameter int STD_W1L      = 750,
  parameter int STD_W0L      = 7500,
  parameter int STD_RL       = 750,
  parameter int STD_MSR      = 1875,
  parameter int STD_SLOT     = 8750,
  parameter int STD_RSTL     = 60000,
  parameter int STD_RSTH     = 36000,
  parameter int STD_RSTH_EXT = 60000,
  parameter int STD_MSP      = 8750,
  parameter int OD_W1L       = 125,
  parameter int OD_W0L       = 938,
  parameter int OD_RL        = 125,
  parameter int OD_MSR       = 250,
  parameter int OD_SLOT      = 1250,
  parameter int OD_RSTL      = 8750,
  parameter int OD_RSTH      = 5000,
  parameter int OD_RSTH_EXT  = 6000,
  parameter int OD_MSP       = 1063
) (
  input  op_e           op,
  input  logic          wr_bit,
  input  logic          fast,
  input  logic          ext_rst,
  output logic [CW-1:0] low_len,
  output logic [CW-1:0] smp_at,
  output logic [CW-1:0] total,
  output logic          smp_en
);
  logic [CW-1:0] rstl, rsth, msp, slot, w1l, w0l, rl, msr;

  // profile pick (R9)
  always_comb begin
    rstl = fast ? CW'(OD_RSTL) : CW'(STD_RSTL);
    msp  = fast ? CW'(OD_MSP)  : CW'(STD_MSP);
    slot = fast ? CW'(OD_SLOT) : CW'(STD_SLOT);
    w1l  = fast ? CW'(OD_W1L)  : CW'(STD_W1L);
    w0l  = fast ? CW'(OD_W0L)  : CW'(STD_W0L);
    rl   = fast ? CW'(OD_RL)   : CW'(STD_RL);
    msr  = fast ? CW'(OD_MSR)  : CW'(STD_MSR);
    if (fast) rsth = ext_rst ? CW'(OD_RSTH_EXT)  : CW'(OD_RSTH);
    else      rsth = ext_rst ? CW'(STD_RSTH_EXT) : CW'(STD_RSTH);
  end

  always_comb begin
    low_len = CW'(1);
    smp_at  = '0;
    total   = CW'(1);
    smp_en  = 1'b0;
    case (op)
      OP_RESET: begin
        low_len = rstl;
        smp_at  = rstl + msp;
        total   = rstl + rsth;
        smp_en  = 1'b1;
      end
      OP_WRITE: begin
        low_len = wr_bit ? w1l : w0l;
        total   = slot;
      end
      OP_READ: begin
        low_len = rl;
        smp_at  = msr;
        total   = slot;
        smp_en  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/owm_phase_ctr.sv
module owm_phase_ctr #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign last = busy_q && (cnt_q == total - CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign cnt  = cnt_q;
  assign busy = busy_q;

  // a running operation advances one step per cycle, whatever arrives (R2)
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/owm_sampler.sv
module owm_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic is_reset,
  input  logic line,
  output logic presence,
  output logic rd_bit
);
  logic pres_q, pres_d, bit_q, bit_d;

  always_comb begin
    pres_d = pres_q;
    bit_d  = bit_q;
    if (hit && is_reset)  pres_d = !line;
    if (hit && !is_reset) bit_d  = line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      pres_q <= pres_d;
      bit_q  <= bit_d;
    end
  end

  assign presence = pres_q;
  assign rd_bit   = bit_q;

  // results change only at a sample edge (R7)
  assert_hold_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(pres_q) && $stable(bit_q)));
endmodule

// File: rtl/owm_bit_engine.sv
module owm_bit_engine
  import owm_pkg::*;
#(
  parameter int STD_W1L      = 750,
  parameter int STD_W0L      = 7500,
  parameter int STD_RL       = 750,
  parameter int STD_MSR      = 1875,
  parameter int STD_SLOT     = 8750,
  parameter int STD_RSTL     = 60000,
  parameter int STD_RSTH     = 36000,
  parameter int STD_RSTH_EXT = 60000,
  parameter int STD_MSP      = 8750,
  parameter int OD_W1L       = 125,
  parameter int OD_W0L       = 938,
  parameter int OD_RL        = 125,
  parameter int OD_MSR       = 250,
  parameter int OD_SLOT      = 1250,
  parameter int OD_RSTL      = 8750,
  parameter int OD_RSTH      = 5000,
  parameter int OD_RSTH_EXT  = 6000,
  parameter int OD_MSP       = 1063
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  input  logic       cmd_fast,
  input  logic       cmd_ext_rst,
  input  logic       bus_in,
  output logic       bus_pull,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit
);
  localparam int STD_MAX = STD_RSTL + STD_RSTH_EXT;
  localparam int OD_MAX  = OD_RSTL + OD_RSTH_EXT;
  localparam int CW      = $clog2((STD_MAX > OD_MAX ? STD_MAX : OD_MAX) + 1) + 1;

  op_e           op_q, op_d;
  logic          bit_q, bit_d, fast_q, fast_d, ext_q, ext_d;
  logic          pull_q, pull_d, done_q, done_d;
  logic          start, last, smp_en, hit;
  logic [CW-1:0] cnt, low_len, smp_at, total;

  assign start = cmd_valid && !busy && (op_e'(cmd_op) != OP_NONE);

  // command capture, enabled by start
  always_comb begin
    op_d   = op_q;
    bit_d  = bit_q;
    fast_d = fast_q;
    ext_d  = ext_q;
    if (start) begin
      op_d   = op_e'(cmd_op);
      bit_d  = cmd_bit;
      fast_d = cmd_fast;
      ext_d  = cmd_ext_rst;
    end
  end

  owm_timing_sel #(
    .CW(CW),
    .STD_W1L(STD_W1L), .STD_W0L(STD_W0L), .STD_RL(STD_RL), .STD_MSR(STD_MSR),
    .STD_SLOT(STD_SLOT), .STD_RSTL(STD_RSTL), .STD_RSTH(STD_RSTH),
    .STD_RSTH_EXT(STD_RSTH_EXT), .STD_MSP(STD_MSP),
    .OD_W1L(OD_W1L), .OD_W0L(OD_W0L), .OD_RL(OD_RL), .OD_MSR(OD_MSR),
    .OD_SLOT(OD_SLOT), .OD_RSTL(OD_RSTL), .OD_RSTH(OD_RSTH),
    .OD_RSTH_EXT(OD_RSTH_EXT), .OD_MSP(OD_MSP)
  ) timing_i (
    .op(op_q), .wr_bit(bit_q), .fast(fast_q), .ext_rst(ext_q),
    .low_len(low_len), .smp_at(smp_at), .total(total), .smp_en(smp_en)
  );

  owm_phase_ctr #(.CW(CW)) phase_i (
    .clk(clk), .rst_n(rst_n), .start(start), .total(total),
    .cnt(cnt), .busy(busy), .last(last)
  );

  assign hit = busy && smp_en && (cnt == smp_at);

  owm_sampler sampler_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .is_reset(op_q == OP_RESET),
    .line(bus_in), .presence(presence), .rd_bit(rd_bit)
  );

  // pulldown for cycles 0 .. L-1 after the accepting edge
  always_comb begin
    pull_d = 1'b0;
    if (start)                    pull_d = 1'b1;
    else if (busy && !last)       pull_d = (cnt + CW'(1)) < low_len;
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      bit_q  <= 1'b0;
      fast_q <= 1'b0;
      ext_q  <= 1'b0;
      pull_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      op_q   <= op_d;
      bit_q  <= bit_d;
      fast_q <= fast_d;
      ext_q  <= ext_d;
      pull_q <= pull_d;
      done_q <= done_d;
    end
  end

  assign bus_pull = pull_q;
  assign done     = done_q;

  assert_pull_in_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull |-> busy);
  assert_pull_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_pull);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/owm_bit_engine_tb_top.sv
module owm_bit_engine_tb_top;
  localparam int S_W1L = 3, S_W0L = 30, S_RL = 3, S_MSR = 8, S_SLOT = 36;
  localparam int S_RSTL = 200, S_RSTH = 100, S_RSTX = 240, S_MSP = 30;
  localparam int F_W1L = 1, F_W0L = 4, F_RL = 1, F_MSR = 2, F_SLOT = 6;
  localparam int F_RSTL = 24, F_RSTH = 12, F_RSTX = 24, F_MSP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0, cmd_fast = 1'b0, cmd_ext_rst = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic slave_low = 1'b0;
  logic bus_in, bus_pull, busy, done, presence, rd_bit;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  assign bus_in = !(bus_pull || slave_low);

  owm_bit_engine #(
    .STD_W1L(S_W1L), .STD_W0L(S_W0L), .STD_RL(S_RL), .STD_MSR(S_MSR),
    .STD_SLOT(S_SLOT), .STD_RSTL(S_RSTL), .STD_RSTH(S_RSTH),
    .STD_RSTH_EXT(S_RSTX), .STD_MSP(S_MSP),
    .OD_W1L(F_W1L), .OD_W0L(F_W0L), .OD_RL(F_RL), .OD_MSR(F_MSR),
    .OD_SLOT(F_SLOT), .OD_RSTL(F_RSTL), .OD_RSTH(F_RSTH),
    .OD_RSTH_EXT(F_RSTX), .OD_MSP(F_MSP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .cmd_fast(cmd_fast), .cmd_ext_rst(cmd_ext_rst),
    .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy), .done(done),
    .presence(presence), .rd_bit(rd_bit)
  );

  // vector: {op[2], bit, fast, ext, win_lo[10], win_hi[10], expected result}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 10'd205,  10'd300, 1'b1},
    {2'd0, 1'b0, 1'b0, 1'b0, 10'd231,  10'd260, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b1, 10'd220,  10'd230, 1'b1},
    {2'd0, 1'b0, 1'b1, 1'b0, 10'd26,   10'd40,  1'b1},
    {2'd0, 1'b0, 1'b1, 1'b1, 10'd1023, 10'd0,   1'b0},
    {2'd1, 1'b1, 1'b0, 1'b0, 10'd1023, 10'd0,   1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 10'd1023, 10'd0,   1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0, 10'd1023, 10'd0,   1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 10'd1023, 10'd0,   1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'd0,    10'd8,   1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 10'd0,    10'd7,   1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 10'd0,    10'd2,   1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 10'd1023, 10'd0,   1'b1}
  };

  function automatic int exp_low(input logic [1:0] op, input logic b, input logic f);
    if (op == 2'd0) return f ? F_RSTL : S_RSTL;
    if (op == 2'd2) return f ? F_RL : S_RL;
    if (b) return f ? F_W1L : S_W1L;
    return f ? F_W0L : S_W0L;
  endfunction

  function automatic int exp_total(input logic [1:0] op, input logic f, input logic x);
    if (op != 2'd0) return f ? F_SLOT : S_SLOT;
    if (f) return F_RSTL + (x ? F_RSTX : F_RSTH);
    return S_RSTL + (x ? S_RSTX : S_RSTH);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int m_pull, m_busy, m_done, m_done_k, m_pull0;

  // issue one command, measure its waveform at falling edges, cycle k = 0 .. T+2
  task automatic run_op(input logic [1:0] op, input logic b, input logic f, input logic x,
                        input int lo, input int hi, input int tlen, input bit poke);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; cmd_fast = f; cmd_ext_rst = x;
    @(posedge clk);
    m_pull = 0; m_busy = 0; m_done = 0; m_done_k = -1; m_pull0 = 0;
    for (int k = 0; k <= tlen + 2; k++) begin
      @(negedge clk);
      slave_low = (k >= lo) && (k <= hi);
      if (poke && k >= 2 && k <= 4) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_bit = 1'b0;
      end else begin
        cmd_valid = 1'b0;
      end
      if (bus_pull) m_pull++;
      if (k == 0) m_pull0 = bus_pull;
      if (busy) m_busy++;
      if (done) begin m_done++; if (m_done_k < 0) m_done_k = k; end
    end
    slave_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pres_before, bit_before;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "pull in reset", bus_pull, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", {busy, bus_pull, done, presence, rd_bit}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic b, f, x, e;
      int lo, hi, tl, ll;
      op = VEC[v][25:24]; b = VEC[v][23]; f = VEC[v][22]; x = VEC[v][21];
      lo = int'(VEC[v][20:11]); hi = int'(VEC[v][10:1]); e = VEC[v][0];
      tl = exp_total(op, f, x);
      ll = exp_low(op, b, f);
      pres_before = presence; bit_before = rd_bit;
      run_op(op, b, f, x, lo, hi, tl, 1'b0);
      check(op == 2'd0 ? "R3" : (op == 2'd1 ? "R6" : "R7"), $sformatf("v%0d pull cycles", v), m_pull, ll);
      check("R9", $sformatf("v%0d pull from cycle 0", v), m_pull0, 1);
      check(op == 2'd0 ? "R5" : "R8", $sformatf("v%0d busy cycles", v), m_busy, tl);
      check("R8", $sformatf("v%0d done cycle", v), m_done_k, tl);
      check("R8", $sformatf("v%0d done count", v), m_done, 1);
      if (op == 2'd0) check("R4", $sformatf("v%0d presence", v), presence, e);
      if (op == 2'd2) check("R7", $sformatf("v%0d read bit", v), rd_bit, e);
      if (op == 2'd1) check("R7", $sformatf("v%0d write keeps results", v),
                            {presence, rd_bit}, {pres_before[0], bit_before[0]});
    end

    // R2: commands during busy are ignored
    run_op(2'd1, 1'b1, 1'b0, 1'b0, 1023, 0, S_SLOT, 1'b1);
    check("R2", "pull with busy poke", m_pull, S_W1L);
    check("R2", "busy with busy poke", m_busy, S_SLOT);

    // R2: op 11 is not accepted
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2", "op 11 busy", busy, 0);
    check("R2", "op 11 pull", bus_pull, 0);

    // R1: reset in mid operation aborts it
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_fast = 1'b0; cmd_ext_rst = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", "pull before abort", bus_pull, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "abort clears busy and pull", {busy, bus_pull}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "stays idle after abort", {busy, bus_pull, done}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule